// File: doc/BRIEF.md
# ModR/M and SIB Addressing Decoder

This block sits behind the opcode stage of an instruction decoder and turns the addressing bytes of an instruction into an operand descriptor. It accepts a byte stream through a valid/ready handshake. The first byte accepted is the ModR/M byte. Depending on its fields and the current address size, the block then takes an optional SIB byte and zero, 1, 2 or 4 displacement bytes. The REX extension bits and the address size are sampled together with the ModR/M byte.

When the last addressing byte has been taken, the block holds a one-cycle `done` strobe. In that cycle it presents the following:
- the register-operand index;
- the base and index selectors, each with a valid bit;
- the scale;
- the displacement width, and the displacement sign-extended to `DISP_W` bits;
- an instruction-pointer-relative flag;
- the number of bytes it consumed.

Register-class fixups and the address arithmetic are left to later stages.

Address-size code on `addr_size`: 0 is 16-bit, 1 is 32-bit, 2 is 64-bit, and 3 is reserved. For the 16-bit form, `base_idx` carries the 3-bit r/m base-pair code (0..7) in its low bits.

Top module: `addr_mode_decoder`

## Requirements
- R1: When mod (ModR/M bits 7:6) is 3, `rm_is_reg` is 1 and `base_idx` = {rex_b, r/m}. The register index is {0, r/m} under 16-bit size. No SIB byte and no displacement are taken, and `length` is 1.
- R2: Under 16-bit size, mod=0 with r/m=6 gives no base and a 2-byte displacement. mod=1 gives a 1-byte displacement and mod=2 a 2-byte one, each with base pair code r/m. mod=0 with any other r/m takes no displacement. REX bits are ignored, and `reg_idx` = {0, reg}.
- R3: Under 32/64-bit size with mod≠3 and r/m bits 2:0 equal to 4, a SIB byte is taken and `sib_used` is 1. Otherwise `sib_used` is 0.
- R4: Under 32/64-bit size, mod=0 with r/m bits 2:0 equal to 5 gives no base and a 4-byte displacement. `rip_rel` is 1 only when the size is 64-bit.
- R5: Under 32/64-bit size without the escape cases of R4 and R8, mod=0 takes no displacement, mod=1 takes 1 byte and mod=2 takes 4 bytes. The base is {rex_b, r/m}.
- R6: `reg_idx` = {rex_r, reg}, where reg is ModR/M bits 5:3. From the SIB byte, the index is {rex_x, SIB bits 5:3} and the base is {rex_b, SIB bits 2:0}.
- R7: The SIB index value 4 (rex_x clear) clears `index_valid`, while value 12 stays valid. `scale` equals SIB bits 7:6, giving a multiplier of 1, 2, 4 or 8.
- R8: When the SIB base bits 2:0 are 5, mod=0 gives no base and a 4-byte displacement. mod=1 and mod=2 keep base {rex_b, 5} with a 1-byte or a 4-byte displacement.
- R9: A SIB byte is never taken under 16-bit size. With the reserved size code 3, `addr_err` is 1 and `done` follows the ModR/M byte alone, with `length` 1.
- R10: Displacement bytes arrive least significant first. The displacement is sign-extended from its width to `DISP_W` bits, and is zero when there is none.
- R11: `done` is high for exactly one cycle, starting the cycle after the last byte is accepted. `in_ready` is low in that cycle, and `length` counts ModR/M, SIB and displacement bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| rex_r | input | 1 | Register-field extension bit |
| rex_x | input | 1 | SIB index extension bit |
| rex_b | input | 1 | r/m or SIB base extension bit |
| addr_size | input | 2 | 0=16, 1=32, 2=64, 3 reserved |
| done | output | 1 | Descriptor valid strobe |
| addr_err | output | 1 | Reserved address size seen |
| rm_is_reg | output | 1 | r/m names a register directly |
| reg_idx | output | 4 | Register operand index |
| base_valid | output | 1 | A base register is used |
| base_idx | output | 4 | Base selector (or r/m register) |
| index_valid | output | 1 | An index register is used |
| index_idx | output | 4 | Index selector |
| scale | output | 2 | log2 of index multiplier |
| rip_rel | output | 1 | Instruction-pointer-relative form |
| sib_used | output | 1 | A SIB byte was taken |
| disp_bytes | output | 3 | Displacement width in bytes |
| disp | output | DISP_W | Sign-extended displacement |
| length | output | 3 | Bytes consumed |

## Verification
The assertions take two things for granted:
- `rex_r`, `rex_x`, `rex_b` and `addr_size` are meaningful only in the cycle the ModR/M byte is accepted.
- The stream never offers a byte that belongs to the next instruction while `done` is high. The block itself enforces this by holding `in_ready` low.

The stimulus holds the extension bits and the size steady for a whole instruction. It offers bytes only when `in_ready` is high, and it inserts random idle gaps. Random ModR/M and SIB values cover every mod, r/m, index and base combination, including the escape values. Directed cases pin the 16-bit base-pair forms, the frame-pointer base, index 12 and the reserved size.

// File: rtl/amd_pkg.sv
package amd_pkg;
  localparam int unsigned MAX_DISP = 4;

  typedef enum logic [1:0] {
    SZ16  = 2'd0,
    SZ32  = 2'd1,
    SZ64  = 2'd2,
    SZBAD = 2'd3
  } asize_e;

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2,
    ST_DONE  = 2'd3
  } dec_state_e;

  typedef struct packed {
    logic       need_sib;
    logic [2:0] disp_len;
    logic       base_valid;
    logic [3:0] base_idx;
    logic       rip_rel;
    logic       rm_is_reg;
    logic [3:0] reg_idx;
  } mrm_info_t;

  typedef struct packed {
    logic       index_valid;
    logic [3:0] index_idx;
    logic [1:0] scale;
    logic       base_valid;
    logic [3:0] base_idx;
    logic [2:0] disp_len;
  } sib_info_t;

  // Widen a little-endian gathered displacement from its byte width to 64 bits.
  function automatic logic [63:0] widen_disp(input logic [31:0] raw, input logic [2:0] nbytes);
    logic [63:0] r;
    case (nbytes)
      3'd1:    r = {{56{raw[7]}}, raw[7:0]};
      3'd2:    r = {{48{raw[15]}}, raw[15:0]};
      3'd4:    r = {{32{raw[31]}}, raw[31:0]};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/amd_modrm_dec.sv
module amd_modrm_dec
  import amd_pkg::*;
(
  input  logic [7:0] modrm,
  input  logic       ext_r,
  input  logic       ext_b,
  input  asize_e     asize,
  output mrm_info_t  info
);
  logic [1:0] md;
  logic [2:0] rg;
  logic [2:0] rm;

  assign md = modrm[7:6];
  assign rg = modrm[5:3];
  assign rm = modrm[2:0];

  always_comb begin
    info = '0;
    if (asize == SZ16) begin
      info.reg_idx  = {1'b0, rg};
      info.base_idx = {1'b0, rm};
      case (md)
        2'd0: begin
          info.base_valid = (rm != 3'd6);
          info.disp_len   = (rm == 3'd6) ? 3'd2 : 3'd0;
        end
        2'd1: begin info.base_valid = 1'b1; info.disp_len = 3'd1; end
        2'd2: begin info.base_valid = 1'b1; info.disp_len = 3'd2; end
        default: info.rm_is_reg = 1'b1;
      endcase
    end else if (asize != SZBAD) begin
      info.reg_idx  = {ext_r, rg};
      info.base_idx = {ext_b, rm};
      if (md == 2'd3) begin
        info.rm_is_reg = 1'b1;
      end else begin
        info.need_sib = (rm == 3'd4);
        case (md)
          2'd0: begin
            if (rm == 3'd5) begin
              info.disp_len = 3'd4;
              info.rip_rel  = (asize == SZ64);
            end else begin
              info.base_valid = !info.need_sib;
            end
          end
          2'd1: begin info.base_valid = !info.need_sib; info.disp_len = 3'd1; end
          default: begin info.base_valid = !info.need_sib; info.disp_len = 3'd4; end
        endcase
      end
    end
  end
endmodule

// File: rtl/amd_sib_dec.sv
module amd_sib_dec
  import amd_pkg::*;
(
  input  logic [7:0] sib,
  input  logic [1:0] md,
  input  logic       ext_x,
  input  logic       ext_b,
  output sib_info_t  info
);
  logic [2:0] sbase;
  assign sbase = sib[2:0];

  always_comb begin
    info.scale       = sib[7:6];
    info.index_idx   = {ext_x, sib[5:3]};
    info.index_valid = (info.index_idx != 4'd4);
    info.base_idx    = {ext_b, sbase};
    info.base_valid  = 1'b1;
    case (md)
      2'd0: begin
        if (sbase == 3'd5) begin
          info.base_valid = 1'b0;
          info.disp_len   = 3'd4;
        end else begin
          info.disp_len = 3'd0;
        end
      end
      2'd1:    info.disp_len = 3'd1;
      default: info.disp_len = 3'd4;
    endcase
  end
endmodule

// File: rtl/amd_disp_gather.sv
module amd_disp_gather
  import amd_pkg::*;
#(
  parameter int unsigned LANES = MAX_DISP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 take,
  input  logic [7:0]           data,
  output logic [8*LANES-1:0]   raw,
  output logic [2:0]           count
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          raw[8*g +: 8] <= '0;
      else if (clear)                      raw[8*g +: 8] <= '0;
      else if (take && count == 3'(g))     raw[8*g +: 8] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (take)  count <= count + 3'd1;
  end
endmodule

// File: rtl/addr_mode_decoder.sv
module addr_mode_decoder
  import amd_pkg::*;
#(
  parameter int unsigned DISP_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              rex_r,
  input  logic              rex_x,
  input  logic              rex_b,
  input  logic [1:0]        addr_size,
  output logic              done,
  output logic              addr_err,
  output logic              rm_is_reg,
  output logic [3:0]        reg_idx,
  output logic              base_valid,
  output logic [3:0]        base_idx,
  output logic              index_valid,
  output logic [3:0]        index_idx,
  output logic [1:0]        scale,
  output logic              rip_rel,
  output logic              sib_used,
  output logic [2:0]        disp_bytes,
  output logic [DISP_W-1:0] disp,
  output logic [2:0]        length
);
  dec_state_e st;
  logic [7:0] modrm_q, sib_q;
  logic [2:0] ext_q;
  asize_e     asize_q;
  logic       sib_q_used;
  logic [2:0] byte_cnt;

  logic       byte_fire;
  logic       first_fire, sib_fire, disp_fire;
  logic [7:0] cur_modrm, cur_sib;
  logic [2:0] cur_ext;
  asize_e     cur_asize;
  mrm_info_t  mi;
  sib_info_t  si;
  logic [2:0] disp_need;
  logic [31:0] disp_raw;
  logic [2:0]  disp_cnt;
  logic [63:0] disp_wide;

  assign in_ready   = (st != ST_DONE);
  assign byte_fire  = in_valid && in_ready;
  assign first_fire = byte_fire && (st == ST_MODRM);
  assign sib_fire   = byte_fire && (st == ST_SIB);
  assign disp_fire  = byte_fire && (st == ST_DISP);

  assign cur_modrm = (st == ST_MODRM) ? in_data : modrm_q;
  assign cur_sib   = (st == ST_SIB)   ? in_data : sib_q;
  assign cur_ext   = (st == ST_MODRM) ? {rex_r, rex_x, rex_b} : ext_q;
  assign cur_asize = (st == ST_MODRM) ? asize_e'(addr_size) : asize_q;

  amd_modrm_dec u_mrm (
    .modrm (cur_modrm),
    .ext_r (cur_ext[2]),
    .ext_b (cur_ext[0]),
    .asize (cur_asize),
    .info  (mi)
  );

  amd_sib_dec u_sib (
    .sib   (cur_sib),
    .md    (modrm_q[7:6]),
    .ext_x (ext_q[1]),
    .ext_b (ext_q[0]),
    .info  (si)
  );

  amd_disp_gather #(.LANES(MAX_DISP)) u_disp (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (first_fire),
    .take  (disp_fire),
    .data  (in_data),
    .raw   (disp_raw),
    .count (disp_cnt)
  );

  assign disp_need = sib_q_used ? si.disp_len : mi.disp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_MODRM;
      modrm_q    <= '0;
      sib_q      <= '0;
      ext_q      <= '0;
      asize_q    <= SZ16;
      sib_q_used <= 1'b0;
      byte_cnt   <= '0;
    end else begin
      case (st)
        ST_MODRM: if (first_fire) begin
          modrm_q    <= in_data;
          ext_q      <= {rex_r, rex_x, rex_b};
          asize_q    <= asize_e'(addr_size);
          sib_q      <= '0;
          sib_q_used <= mi.need_sib;
          byte_cnt   <= 3'd1;
          if (mi.need_sib)            st <= ST_SIB;
          else if (mi.disp_len != 0)  st <= ST_DISP;
          else                        st <= ST_DONE;
        end
        ST_SIB: if (sib_fire) begin
          sib_q    <= in_data;
          byte_cnt <= byte_cnt + 3'd1;
          st       <= (si.disp_len != 0) ? ST_DISP : ST_DONE;
        end
        ST_DISP: if (disp_fire) begin
          byte_cnt <= byte_cnt + 3'd1;
          if (disp_cnt + 3'd1 == disp_need) st <= ST_DONE;
        end
        default: st <= ST_MODRM;
      endcase
    end
  end

  assign disp_wide   = widen_disp(disp_raw, disp_need);
  assign done        = (st == ST_DONE);
  assign addr_err    = (asize_q == SZBAD);
  assign rm_is_reg   = mi.rm_is_reg;
  assign reg_idx     = mi.reg_idx;
  assign sib_used    = sib_q_used;
  assign base_valid  = sib_q_used ? si.base_valid  : mi.base_valid;
  assign base_idx    = sib_q_used ? si.base_idx    : mi.base_idx;
  assign index_valid = sib_q_used && si.index_valid;
  assign index_idx   = sib_q_used ? si.index_idx   : 4'd0;
  assign scale       = sib_q_used ? si.scale       : 2'd0;
  assign rip_rel     = mi.rip_rel;
  assign disp_bytes  = disp_need;
  assign disp        = disp_wide[DISP_W-1:0];
  assign length      = byte_cnt;
endmodule

// File: rtl/amd_checker.sv
module amd_checker #(
  parameter int unsigned DISP_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              in_ready,
  input logic              byte_fire,
  input logic              addr_err,
  input logic              rm_is_reg,
  input logic              sib_used,
  input logic [1:0]        asize_q,
  input logic              base_valid,
  input logic              index_valid,
  input logic [3:0]        index_idx,
  input logic              rip_rel,
  input logic [2:0]        disp_bytes,
  input logic [DISP_W-1:0] disp,
  input logic [2:0]        length
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_NO_TAKE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !byte_fire); // R11
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(byte_fire)); // R11
  AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done && !addr_err |-> length == 3'd1 + {2'b0, sib_used} + disp_bytes); // R11
  AST_REG_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    done && rm_is_reg |-> length == 3'd1 && !sib_used && disp_bytes == 3'd0); // R1
  AST_NO_SIB_16: assert property (@(posedge clk) disable iff (!rst_n)
    done && asize_q == 2'd0 |-> !sib_used && !index_valid); // R9
  AST_RESERVED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    done && addr_err |-> length == 3'd1); // R9
  AST_NO_INDEX_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    done && index_valid |-> index_idx != 4'd4); // R7
  AST_RIP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    done && rip_rel |-> !base_valid && !sib_used && disp_bytes == 3'd4 && asize_q == 2'd2); // R4
  AST_DISP8_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    done && disp_bytes == 3'd1 |-> disp[DISP_W-1:7] == '0 || disp[DISP_W-1:7] == '1); // R10
endmodule

bind addr_mode_decoder amd_checker #(.DISP_W(DISP_W)) u_amd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .in_ready    (in_ready),
  .byte_fire   (byte_fire),
  .addr_err    (addr_err),
  .rm_is_reg   (rm_is_reg),
  .sib_used    (sib_used),
  .asize_q     (asize_q),
  .base_valid  (base_valid),
  .index_valid (index_valid),
  .index_idx   (index_idx),
  .rip_rel     (rip_rel),
  .disp_bytes  (disp_bytes),
  .disp        (disp),
  .length      (length)
);

// File: tb/addr_mode_decoder_test.sv
module addr_mode_decoder_test;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic rex_r = 0, rex_x = 0, rex_b = 0;
  logic [1:0] addr_size = 2'd1;
  logic done, addr_err, rm_is_reg, base_valid, index_valid, rip_rel, sib_used;
  logic [3:0] reg_idx, base_idx, index_idx;
  logic [1:0] scale;
  logic [2:0] disp_bytes, length;
  logic [DW-1:0] disp;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  addr_mode_decoder #(.DISP_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b), .addr_size(addr_size),
    .done(done), .addr_err(addr_err), .rm_is_reg(rm_is_reg), .reg_idx(reg_idx),
    .base_valid(base_valid), .base_idx(base_idx), .index_valid(index_valid),
    .index_idx(index_idx), .scale(scale), .rip_rel(rip_rel), .sib_used(sib_used),
    .disp_bytes(disp_bytes), .disp(disp), .length(length)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected descriptor, derived from the requirement text
  typedef struct {
    bit       err, isreg, sib, bv, iv, rip;
    bit [3:0] rg, b, ix;
    bit [1:0] sc;
    int       dn;
  } exp_t;

  function automatic exp_t model(input bit [7:0] m, input bit [7:0] s,
                                 input bit r, input bit x, input bit bb, input bit [1:0] sz);
    exp_t e;
    int md = m[7:6];
    int rm = m[2:0];
    e = '{default: 0};
    if (sz == 3) begin e.err = 1; return e; end
    if (sz == 0) begin
      e.rg = {1'b0, m[5:3]};
      e.b  = {1'b0, m[2:0]};
      if (md == 3) e.isreg = 1;
      else if (md == 0 && rm == 6) e.dn = 2;
      else begin e.bv = 1; e.dn = (md == 1) ? 1 : (md == 2) ? 2 : 0; end
      return e;
    end
    e.rg = {r, m[5:3]};
    if (md == 3) begin e.isreg = 1; e.b = {bb, m[2:0]}; return e; end
    if (rm == 4) begin
      e.sib = 1;
      e.sc  = s[7:6];
      e.ix  = {x, s[5:3]};
      e.iv  = (e.ix != 4);
      e.b   = {bb, s[2:0]};
      if (md == 0 && s[2:0] == 5) e.dn = 4;
      else begin e.bv = 1; e.dn = (md == 0) ? 0 : (md == 1) ? 1 : 4; end
      return e;
    end
    if (md == 0 && rm == 5) begin e.dn = 4; e.rip = (sz == 2); return e; end
    e.bv = 1;
    e.b  = {bb, m[2:0]};
    e.dn = (md == 0) ? 0 : (md == 1) ? 1 : 4;
    return e;
  endfunction

  task automatic send_byte(input bit [7:0] v, input bit gaps);
    if (gaps) repeat ($urandom % 3) @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_insn(input bit [7:0] m, input bit [7:0] s, input bit [31:0] dv,
                          input bit r, input bit x, input bit bb, input bit [1:0] sz, input bit gaps);
    exp_t e;
    logic [63:0] dexp;
    e = model(m, s, r, x, bb, sz);
    rex_r = r; rex_x = x; rex_b = bb; addr_size = sz;
    send_byte(m, gaps);
    if (e.sib) send_byte(s, gaps);
    for (int i = 0; i < e.dn; i++) send_byte(dv[8*i +: 8], gaps);
    // the last accepted edge moved the block into its done cycle
    chk(done === 1'b1, "R11 done after last byte", 64'(done), 1);
    chk(length === 3'(1 + e.sib + e.dn), "R11 length", 64'(length), 64'(1 + e.sib + e.dn));
    chk(addr_err === e.err, "R9 addr_err", 64'(addr_err), 64'(e.err));
    if (!e.err) begin
      chk(rm_is_reg === e.isreg, "R1 rm_is_reg", 64'(rm_is_reg), 64'(e.isreg));
      chk(sib_used === e.sib, "R3 sib_used", 64'(sib_used), 64'(e.sib));
      chk(reg_idx === e.rg, "R6 reg_idx", 64'(reg_idx), 64'(e.rg));
      chk(base_valid === e.bv, "R5 base_valid", 64'(base_valid), 64'(e.bv));
      if (e.bv || e.isreg || (e.sib && e.dn != 4))
        chk(base_idx === e.b, "R8 base_idx", 64'(base_idx), 64'(e.b));
      chk(index_valid === e.iv, "R7 index_valid", 64'(index_valid), 64'(e.iv));
      if (e.iv) chk(index_idx === e.ix, "R6 index_idx", 64'(index_idx), 64'(e.ix));
      if (e.sib) chk(scale === e.sc, "R7 scale", 64'(scale), 64'(e.sc));
      chk(rip_rel === e.rip, "R4 rip_rel", 64'(rip_rel), 64'(e.rip));
      chk(disp_bytes === 3'(e.dn), "R2 disp_bytes", 64'(disp_bytes), 64'(e.dn));
      case (e.dn)
        1: dexp = 64'(signed'(dv[7:0]));
        2: dexp = 64'(signed'(dv[15:0]));
        4: dexp = 64'(signed'(dv[31:0]));
        default: dexp = '0;
      endcase
      chk(disp === dexp, "R10 disp", disp, dexp);
    end
    @(negedge clk);
    chk(done === 1'b0, "R11 done single cycle", 64'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R11 reset state", {done, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 register direct, 64-bit with rex_b
    run_insn(8'hC5, 8'h00, 32'h0, 0, 0, 1, 2'd2, 0);
    // R2 16-bit forms
    run_insn(8'h06, 8'h00, 32'h0000_8001, 1, 1, 1, 2'd0, 0);
    run_insn(8'h44, 8'h00, 32'h0000_0080, 0, 0, 0, 2'd0, 0);
    run_insn(8'h87, 8'h00, 32'h0000_1234, 0, 0, 0, 2'd0, 0);
    // R4 no-base disp32 under 32 and 64
    run_insn(8'h05, 8'h00, 32'hFFFF_FFF0, 0, 0, 0, 2'd1, 0);
    run_insn(8'h3D, 8'h00, 32'h0000_0100, 1, 0, 0, 2'd2, 0);
    // R8 SIB base 5 with mod 0/1/2, R7 index 4 vs 12
    run_insn(8'h04, 8'hE5, 32'h1234_5678, 0, 0, 1, 2'd2, 0);
    run_insn(8'h44, 8'h65, 32'h0000_00FE, 0, 1, 1, 2'd2, 0);
    run_insn(8'h84, 8'h25, 32'h8000_0000, 0, 0, 0, 2'd1, 0);
    // R9 reserved size
    run_insn(8'h04, 8'h00, 32'h0, 0, 0, 0, 2'd3, 0);
    // R3/R5/R6/R10 random
    for (int k = 0; k < 400; k++) begin
      bit [1:0] sz = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      run_insn(8'($urandom), 8'($urandom), $urandom, 1'($urandom), 1'($urandom),
               1'($urandom), sz, 1'($urandom));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule